// File: doc/BRIEF.md
# Parallel Feed-Forward Equalizer with Decimated LMS Adaptation

This block equalizes a stream of digitized line samples that arrive as a block of eight lanes per clock. The lanes are in time order, with lane 0 the oldest sample of the block. Each lane gets a four-tap FIR output: the cursor tap and three taps on earlier samples. Taps that reach before lane 0 read the tail of the previous block. A binary slicer decides each output. An error is formed as the decided level minus the equalizer output.

The tap coefficients adapt by least-mean-squares, but only from one sample/error pair every sixteen clocks. That pair is lane 0 of the output block present at the decimation tick. A snapshot of the pair is held for a full decimation period before it is applied. The update arithmetic therefore has sixteen clocks to settle while the filter runs at full rate.

A step-size input selects a power-of-two shift. An adapt-enable input freezes the coefficients when it is low. The slicer level is programmable.

Top module: `par_ffe_lms`

## Requirements
- R1: While reset is asserted, every output is zero. After reset, coefficient c0 (the cursor tap) is 1024, which is +0.5 in the Q1.11 format used by all coefficients, and c1..c3 are 0. With adaptation frozen, a lone sample value v therefore yields 1024·v on its own lane and 0 elsewhere.
- R2: `samp_in` carries lane L in bits [L*6 +: 6] as a two's-complement value. `eq_out` lane L occupies bits [L*20 +: 20] and is the signed sum over k=0..3 of c_k·r(n−k), where n is the sample index of that lane. A block sampled at rising edge m appears after edge m+3, using the coefficients held just before edge m+1.
- R3: For lanes 0, 1 and 2, the taps that reach before lane 0 take samples from lanes 5, 6 and 7 of the block sampled one clock earlier, as continuous time order requires.
- R4: `dec_out` bit L is 1 when `eq_out` lane L is zero or positive, and 0 when it is negative.
- R5: `err_out` lane L occupies bits [L*21 +: 21] and equals +slice_lvl·2048 − y when the decision bit is 1, or −slice_lvl·2048 − y when it is 0. Here slice_lvl is an unsigned 6-bit level sampled at the same edge as the output.
- R6: A counter starts at 0 at reset and advances each clock, modulo 16. At every edge where the counter reads 15, adaptation takes place if `adapt_en` is 1. Each c_k becomes c_k + floor(e·r_k / 2^(11+mu_sel)), where e and r_k are the snapshot taken at the previous such edge (zero before the first one). At the same edge, the snapshot is reloaded with the lane 0 error on the outputs and its regressor samples r(n), r(n−1), r(n−2), r(n−3).
- R7: While `adapt_en` is 0, no coefficient changes. A constant input then gives a constant output.
- R8: A coefficient update that would leave the range −2048..+2047 saturates at the nearest end of that range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_in | input | 48 | Eight 6-bit signed samples, lane 0 oldest |
| adapt_en | input | 1 | 1 lets coefficients update at decimation ticks |
| mu_sel | input | 3 | Extra right shift of the LMS step |
| slice_lvl | input | 6 | Unsigned decision level magnitude |
| eq_out | output | 160 | Eight 20-bit signed equalizer outputs |
| dec_out | output | 8 | Per-lane decision, 1 = non-negative |
| err_out | output | 168 | Eight 21-bit signed slicer errors |

## Verification
The assertions check four things on every cycle. The accumulators stay within the bound set by four full-scale products. The coefficients and the snapshot move only at a decimation tick. The coefficients stay still whenever adaptation is frozen.

Only the bench scenarios can show the rest. These are the exact arithmetic of the taps across the block seam, the slicer and error values, and the one-period lag between snapshot capture and coefficient update. They also include step scaling by mu_sel and saturation under a large step. The bench shows these by comparing every lane against a behavioural model across frozen, adapting and saturating runs.

// File: rtl/pffe_pkg.sv
package pffe_pkg;

   typedef enum logic {
      SLICE_NEG = 1'b0,
      SLICE_POS = 1'b1
   } slice_e;

   // a tap reaches into the previous block when it looks further back than the lane index
   function automatic bit tap_from_prev(input int lane, input int tap);
      return lane < tap;
   endfunction

   function automatic int tap_src_lane(input int lane, input int tap, input int lanes);
      return (lane < tap) ? (lane - tap + lanes) : (lane - tap);
   endfunction

endpackage

// File: rtl/pffe_lane_mac.sv
module pffe_lane_mac #(
   parameter int TAPS = 4,
   parameter int SW   = 6,
   parameter int CW   = 12,
   parameter int AW   = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TAPS*SW-1:0] win_i,
   input  logic [TAPS*CW-1:0] coef_i,
   output logic [AW-1:0]      acc_o
);
   localparam int PW    = SW + CW;
   localparam int BOUND = TAPS * (1 << (SW - 1)) * (1 << (CW - 1));

   logic [TAPS-1:0][PW-1:0] prod_q;
   logic signed [AW-1:0]    sum_c;
   logic signed [AW-1:0]    acc_q;

   // stage 1: one registered product per tap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod_q <= '0;
      end else begin
         for (int k = 0; k < TAPS; k++) begin
            prod_q[k] <= $signed(win_i[k*SW +: SW]) * $signed(coef_i[k*CW +: CW]);
         end
      end
   end

   always_comb begin
      sum_c = '0;
      for (int k = 0; k < TAPS; k++) begin
         sum_c = sum_c + AW'($signed(prod_q[k]));
      end
   end

   // stage 2: registered sum
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= sum_c;
   end

   assign acc_o = acc_q;

   assert_acc_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_q <= BOUND) && (acc_q >= -BOUND));

endmodule

// File: rtl/pffe_slicer.sv
module pffe_slicer #(
   parameter int SW   = 6,
   parameter int AW   = 20,
   parameter int EW   = 21,
   parameter int FRAC = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] acc_i,
   input  logic [SW-1:0] lvl_i,
   output logic [AW-1:0] eq_o,
   output logic          dec_o,
   output logic [EW-1:0] err_o
);
   import pffe_pkg::*;

   slice_e               side;
   logic signed [EW-1:0] lvl_s;
   logic signed [EW-1:0] tgt_s;
   logic signed [EW-1:0] err_s;

   assign side  = acc_i[AW-1] ? SLICE_NEG : SLICE_POS;
   assign lvl_s = EW'({1'b0, lvl_i}) <<< FRAC;
   assign tgt_s = (side == SLICE_POS) ? lvl_s : -lvl_s;
   assign err_s = tgt_s - EW'($signed(acc_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eq_o  <= '0;
         dec_o <= 1'b0;
         err_o <= '0;
      end else begin
         eq_o  <= acc_i;
         dec_o <= (side == SLICE_POS);
         err_o <= err_s;
      end
   end

endmodule

// File: rtl/pffe_lms_engine.sv
module pffe_lms_engine #(
   parameter int TAPS  = 4,
   parameter int SW    = 6,
   parameter int CW    = 12,
   parameter int EW    = 21,
   parameter int DECIM = 16,
   parameter int MUW   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               adapt_en,
   input  logic [MUW-1:0]     mu_sel,
   input  logic [EW-1:0]      err_i,
   input  logic [TAPS*SW-1:0] rgr_i,
   output logic [TAPS*CW-1:0] coef_o
);
   localparam int CNTW   = $clog2(DECIM);
   localparam int FRAC   = CW - 1;
   localparam int MW     = EW + SW;
   localparam int MW1    = MW + 1;
   localparam int HI     = (1 << (CW - 1)) - 1;
   localparam int LO     = -(1 << (CW - 1));
   localparam int C0_RST = 1 << (CW - 2);

   logic [CNTW-1:0]         cnt_q;
   logic                    tick;
   logic signed [EW-1:0]    snap_e_q;
   logic [TAPS*SW-1:0]      snap_r_q;
   logic [TAPS-1:0][CW-1:0] coef_q;
   logic [TAPS-1:0][CW-1:0] coef_nx;
   logic [7:0]              shamt;

   assign tick  = (cnt_q == CNTW'(DECIM - 1));
   assign shamt = 8'(FRAC) + 8'(mu_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + CNTW'(1);
   end

   // snapshot stays fixed for a whole decimation period, so the step math below
   // has DECIM cycles to settle before it is used
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_e_q <= '0;
         snap_r_q <= '0;
      end else if (tick) begin
         snap_e_q <= err_i;
         snap_r_q <= rgr_i;
      end
   end

   for (genvar k = 0; k < TAPS; k++) begin : g_upd
      logic signed [MW-1:0]  prod_k;
      logic signed [MW-1:0]  step_k;
      logic signed [MW1-1:0] sum_k;

      assign prod_k = snap_e_q * $signed(snap_r_q[k*SW +: SW]);
      assign step_k = prod_k >>> shamt;
      assign sum_k  = MW1'($signed(coef_q[k])) + MW1'(step_k);
      assign coef_nx[k] = (sum_k > HI) ? CW'(HI) :
                          (sum_k < LO) ? CW'(LO) : sum_k[CW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < TAPS; k++) begin
            coef_q[k] <= (k == 0) ? CW'(C0_RST) : '0;
         end
      end else if (tick && adapt_en) begin
         coef_q <= coef_nx;
      end
   end

   assign coef_o = coef_q;

   assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !adapt_en |=> $stable(coef_q));

   assert_tick_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(coef_q));

   assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(snap_e_q) && $stable(snap_r_q)));

endmodule

// File: rtl/par_ffe_lms.sv
module par_ffe_lms #(
   parameter int LANES = 8,
   parameter int TAPS  = 4,
   parameter int SW    = 6,
   parameter int CW    = 12,
   parameter int DECIM = 16,
   parameter int MUW   = 3
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [LANES*SW-1:0]               samp_in,
   input  logic                              adapt_en,
   input  logic [MUW-1:0]                    mu_sel,
   input  logic [SW-1:0]                     slice_lvl,
   output logic [LANES*(SW+CW+$clog2(TAPS))-1:0]   eq_out,
   output logic [LANES-1:0]                  dec_out,
   output logic [LANES*(SW+CW+$clog2(TAPS)+1)-1:0] err_out
);
   import pffe_pkg::*;

   localparam int AW        = SW + CW + $clog2(TAPS);
   localparam int EW        = AW + 1;
   localparam int FRAC      = CW - 1;
   localparam int RG_STAGES = 3;

   if (TAPS < 1 || TAPS > LANES + 1) begin : g_chk_taps
      $error("TAPS must lie between 1 and LANES+1");
   end
   if (DECIM < 2 || (DECIM & (DECIM - 1)) != 0) begin : g_chk_decim
      $error("DECIM must be a power of two of at least 2");
   end
   if (EW < SW + 1 + FRAC) begin : g_chk_err
      $error("error width too narrow for the slicer level");
   end

   logic [LANES*SW-1:0]               cur_q;
   logic [LANES*SW-1:0]               prv_q;
   logic [LANES-1:0][TAPS*SW-1:0]     win_all;
   logic [TAPS*CW-1:0]                coef_w;
   logic [RG_STAGES-1:0][TAPS*SW-1:0] rg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
         prv_q <= '0;
      end else begin
         cur_q <= samp_in;
         prv_q <= cur_q;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [AW-1:0] acc_w;

      for (genvar k = 0; k < TAPS; k++) begin : g_win
         localparam int SRC = tap_src_lane(l, k, LANES);
         if (tap_from_prev(l, k)) begin : g_prev
            assign win_all[l][k*SW +: SW] = prv_q[SRC*SW +: SW];
         end else begin : g_cur
            assign win_all[l][k*SW +: SW] = cur_q[SRC*SW +: SW];
         end
      end

      pffe_lane_mac #(.TAPS(TAPS), .SW(SW), .CW(CW), .AW(AW)) u_mac (
         .clk    (clk),
         .rst_n  (rst_n),
         .win_i  (win_all[l]),
         .coef_i (coef_w),
         .acc_o  (acc_w)
      );

      pffe_slicer #(.SW(SW), .AW(AW), .EW(EW), .FRAC(FRAC)) u_slc (
         .clk   (clk),
         .rst_n (rst_n),
         .acc_i (acc_w),
         .lvl_i (slice_lvl),
         .eq_o  (eq_out[l*AW +: AW]),
         .dec_o (dec_out[l]),
         .err_o (err_out[l*EW +: EW])
      );
   end

   // lane 0 regressor delayed to line up with its error at the outputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rg_q <= '0;
      end else begin
         rg_q[0] <= win_all[0];
         for (int s = 1; s < RG_STAGES; s++) begin
            rg_q[s] <= rg_q[s-1];
         end
      end
   end

   pffe_lms_engine #(
      .TAPS(TAPS), .SW(SW), .CW(CW), .EW(EW), .DECIM(DECIM), .MUW(MUW)
   ) u_lms (
      .clk      (clk),
      .rst_n    (rst_n),
      .adapt_en (adapt_en),
      .mu_sel   (mu_sel),
      .err_i    (err_out[EW-1:0]),
      .rgr_i    (rg_q[RG_STAGES-1]),
      .coef_o   (coef_w)
   );

endmodule

// File: tb/par_ffe_lms_tb.sv
`timescale 1ns/1ps
module par_ffe_lms_tb;
   localparam int LANES = 8;
   localparam int TAPS  = 4;
   localparam int SW    = 6;
   localparam int CW    = 12;
   localparam int DECIM = 16;
   localparam int AW    = 20;
   localparam int EW    = 21;
   localparam int FRAC  = 11;

   typedef int blk_t [LANES];
   typedef int cf_t  [TAPS];

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [LANES*SW-1:0] samp_in = '0;
   logic                adapt_en = 1'b0;
   logic [2:0]          mu_sel = '0;
   logic [SW-1:0]       slice_lvl = '0;
   logic [LANES*AW-1:0] eq_out;
   logic [LANES-1:0]    dec_out;
   logic [LANES*EW-1:0] err_out;

   int    checks = 0;
   int    failures = 0;
   bit    cmp_en = 1'b0;
   bit    done = 1'b0;
   string phase = "R1";

   // model state
   blk_t hq[$];
   cf_t  cq[$];
   int   m_coef [TAPS];
   int   m_cnt;
   int   m_snap_e;
   int   m_snap_r [TAPS];
   int   m_y [LANES];
   int   m_d [LANES];
   int   m_e [LANES];
   int   m_r [TAPS];

   always #2 clk = ~clk;

   par_ffe_lms u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .samp_in   (samp_in),
      .adapt_en  (adapt_en),
      .mu_sel    (mu_sel),
      .slice_lvl (slice_lvl),
      .eq_out    (eq_out),
      .dec_out   (dec_out),
      .err_out   (err_out)
   );

   task automatic chk(input bit ok, input string req, input string what, input longint got, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s [%s] %s actual=%0d expected=%0d", req, phase, what, got, exp);
      end
   endtask

   function automatic int sat_c(input longint v);
      if (v > 2047)  return 2047;
      if (v < -2048) return -2048;
      return int'(v);
   endfunction

   function automatic void m_reset();
      blk_t z;
      cf_t  rc;
      foreach (z[i]) z[i] = 0;
      foreach (rc[i]) rc[i] = 0;
      rc[0] = 1024;
      hq.delete();
      cq.delete();
      repeat (4) hq.push_back(z);
      repeat (2) cq.push_back(rc);
      foreach (m_coef[i]) m_coef[i] = rc[i];
      m_cnt = 0;
      m_snap_e = 0;
      foreach (m_snap_r[i]) m_snap_r[i] = 0;
      foreach (m_y[i]) begin m_y[i] = 0; m_d[i] = 0; m_e[i] = 0; end
      foreach (m_r[i]) m_r[i] = 0;
   endfunction

   // behavioural model, one step per rising edge
   always @(posedge clk) begin
      blk_t cb, pb, nb;
      cf_t  uc, old;
      int   ny [LANES];
      int   nr [TAPS];
      longint acc, step;
      int j, v;
      if (!rst_n) begin
         m_reset();
      end else begin
         cb = hq[hq.size()-3];
         pb = hq[hq.size()-4];
         uc = cq[cq.size()-2];
         for (int l = 0; l < LANES; l++) begin
            acc = 0;
            for (int k = 0; k < TAPS; k++) begin
               j = l - k;
               v = (j >= 0) ? cb[j] : pb[j + LANES];
               acc += longint'(uc[k]) * v;
            end
            ny[l] = int'(acc);
         end
         for (int k = 0; k < TAPS; k++) nr[k] = (k == 0) ? cb[0] : pb[LANES - k];
         foreach (old[k]) old[k] = m_coef[k];
         if (m_cnt == DECIM - 1) begin
            if (adapt_en) begin
               for (int k = 0; k < TAPS; k++) begin
                  step = (longint'(m_snap_e) * m_snap_r[k]) >>> (FRAC + int'(mu_sel));
                  m_coef[k] = sat_c(longint'(m_coef[k]) + step);
               end
            end
            m_snap_e = m_e[0];
            foreach (m_snap_r[k]) m_snap_r[k] = m_r[k];
         end
         m_cnt = (m_cnt + 1) % DECIM;
         cq.push_back(old);
         for (int l = 0; l < LANES; l++) nb[l] = int'($signed(samp_in[l*SW +: SW]));
         hq.push_back(nb);
         if (hq.size() > 8) void'(hq.pop_front());
         if (cq.size() > 4) void'(cq.pop_front());
         for (int l = 0; l < LANES; l++) begin
            m_y[l] = ny[l];
            m_d[l] = (ny[l] >= 0) ? 1 : 0;
            m_e[l] = ((ny[l] >= 0) ? 1 : -1) * int'(slice_lvl) * 2048 - ny[l];
         end
         foreach (m_r[k]) m_r[k] = nr[k];
      end
   end

   // compare every lane away from the active edge
   always @(negedge clk) begin
      int gy, ge;
      if (rst_n && cmp_en) begin
         for (int l = 0; l < LANES; l++) begin
            gy = int'($signed(eq_out[l*AW +: AW]));
            ge = int'($signed(err_out[l*EW +: EW]));
            chk(gy == m_y[l], (l < TAPS - 1) ? "R3" : "R2", $sformatf("eq lane %0d", l), gy, m_y[l]);
            chk(int'(dec_out[l]) == m_d[l], "R4", $sformatf("dec lane %0d", l), dec_out[l], m_d[l]);
            chk(ge == m_e[l], "R5", $sformatf("err lane %0d", l), ge, m_e[l]);
         end
      end
   end

   task automatic drive_rand(input int n, input int lo, input int hi);
      repeat (n) begin
         @(negedge clk);
         for (int l = 0; l < LANES; l++) samp_in[l*SW +: SW] = SW'($urandom_range(hi - lo) + lo);
      end
   endtask

   task automatic drive_const(input int n, input int val);
      repeat (n) begin
         @(negedge clk);
         for (int l = 0; l < LANES; l++) samp_in[l*SW +: SW] = SW'(val);
      end
   endtask

   task automatic reset_check();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(eq_out == '0, "R1", "eq_out in reset", eq_out[AW-1:0], 0);
      chk(dec_out == '0, "R1", "dec_out in reset", dec_out, 0);
      chk(err_out == '0, "R1", "err_out in reset", err_out[EW-1:0], 0);
      rst_n = 1'b1;
   endtask

   initial begin
      int ref_y;
      slice_lvl = 6'd10;
      phase = "R1";
      reset_check();
      cmp_en = 1'b1;
      // impulse through reset coefficients, adaptation frozen
      @(negedge clk);
      samp_in = '0;
      samp_in[4*SW +: SW] = 6'd1;
      @(negedge clk);
      samp_in = '0;
      repeat (2) @(negedge clk);
      chk(int'($signed(eq_out[4*AW +: AW])) == 0, "R1", "impulse before latency", $signed(eq_out[4*AW +: AW]), 0);
      @(negedge clk);
      chk(int'($signed(eq_out[4*AW +: AW])) == 1024, "R1", "cursor tap reset value", $signed(eq_out[4*AW +: AW]), 1024);
      chk(int'($signed(eq_out[5*AW +: AW])) == 0, "R1", "first post tap reset value", $signed(eq_out[5*AW +: AW]), 0);

      phase = "R2";
      drive_rand(150, 0, 63);

      phase = "R6";
      slice_lvl = 6'd20;
      mu_sel = 3'd3;
      adapt_en = 1'b1;
      drive_rand(600, 0, 63);
      mu_sel = 3'd6;
      drive_rand(300, 0, 63);

      phase = "R7";
      adapt_en = 1'b0;
      drive_const(10, 7);
      ref_y = int'($signed(eq_out[2*AW +: AW]));
      drive_const(40, 7);
      chk(int'($signed(eq_out[2*AW +: AW])) == ref_y, "R7", "frozen output drift", $signed(eq_out[2*AW +: AW]), ref_y);
      drive_rand(100, 0, 63);

      phase = "R8";
      slice_lvl = 6'd63;
      mu_sel = 3'd0;
      adapt_en = 1'b1;
      drive_const(200, 31);
      drive_rand(300, 0, 63);
      drive_const(150, 6'h21);

      phase = "R1";
      adapt_en = 1'b0;
      cmp_en = 1'b0;
      reset_check();
      cmp_en = 1'b1;
      phase = "R2";
      drive_rand(60, 0, 63);

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog [%s] run did not finish actual=1 expected=0", phase);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule